// File: doc/BRIEF.md
# Four-Phase Handshake Merge Multiplexer

This block joins two request/acknowledge input channels onto a single output channel. Every channel uses four-phase, return-to-zero signalling with bundled data. The block is passive on its two inputs and drives the output handshake itself. All request and acknowledge levels are sampled and driven by one clock.

When one input raises its request, the block latches that input's data onto the output data bus. One cycle later it raises the output request. It then completes the full output handshake: request high, acknowledge high, request low, acknowledge low. Only after that does it clear the output data and acknowledge the input. The acknowledge stays high until the input drops its request. The output cycle is therefore nested inside the input cycle.

The block does not arbitrate. The surrounding logic must never assert both input requests at once.

Top module: `hs_merge_top`

## Requirements
- R1: In the cycle after synchronous reset is sampled high, `out_req`, `x_ack` and `y_ack` are 0 and `out_data` is all zeros.
- R2: After `x_req` is accepted, `out_data` equals the `x_data` that was present when the request was sampled, for as long as `out_req` is high.
- R3: After `y_req` is accepted, `out_data` equals the `y_data` that was present when the request was sampled, for as long as `out_req` is high.
- R4: `out_data` already carries its new value in the cycle before `out_req` rises. It does not change on the cycle on which `out_req` rises.
- R5: `out_data` holds steady for every cycle that `out_req` stays high.
- R6: An input acknowledge rises only after `out_ack` has been seen low again following the output request. At that point `out_req` is low.
- R7: When an input acknowledge rises, `out_data` has been cleared to all zeros.
- R8: An input acknowledge stays high while its request stays high. It falls on the clock edge that samples that request low.
- R9: `out_req` is never high while either input acknowledge is high.
- R10: Only the input whose request was accepted is acknowledged. The two acknowledges are never high together. The two requests are required never to be high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_req | input | 1 | Request of input channel x |
| x_ack | output | 1 | Acknowledge of input channel x |
| x_data | input | DW | Bundled data of input channel x |
| y_req | input | 1 | Request of input channel y |
| y_ack | output | 1 | Acknowledge of input channel y |
| y_data | input | DW | Bundled data of input channel y |
| out_req | output | 1 | Request of the output channel |
| out_ack | input | 1 | Acknowledge of the output channel |
| out_data | output | DW | Bundled data of the output channel |

## Verification
The assertions assume that the environment follows the four-phase protocol.
- An input request is never raised together with the other input request.
- An input's data is steady from its request until its acknowledge.
- `out_ack` only follows `out_req`.

The stimulus stays within these rules because each transfer is driven by one task. That task raises a single request, answers the output request with a variable delay, and releases everything before the next transfer starts. The vectors alternate and repeat the two inputs, and they vary the output acknowledge delay and the time the input request is held.

// File: rtl/hs_merge_pkg.sv
package hs_merge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PUSH  = 3'd2,
    ST_DROP  = 3'd3,
    ST_DONE  = 3'd4
  } merge_state_t;

  typedef enum logic {
    SRC_X = 1'b0,
    SRC_Y = 1'b1
  } merge_src_t;

endpackage

// File: rtl/hs_merge_ctrl.sv
module hs_merge_ctrl
  import hs_merge_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       x_req,
  input  logic       y_req,
  input  logic       out_ack,
  output logic       x_ack,
  output logic       y_ack,
  output logic       out_req,
  output logic       load,
  output merge_src_t load_src,
  output logic       clear
);

  merge_state_t state;
  merge_src_t   src;
  logic         src_req;

  assign src_req = (src == SRC_X) ? x_req : y_req;

  always_comb begin
    load     = 1'b0;
    load_src = SRC_X;
    clear    = 1'b0;
    if (state == ST_IDLE) begin
      if (x_req) begin
        load     = 1'b1;
        load_src = SRC_X;
      end else if (y_req) begin
        load     = 1'b1;
        load_src = SRC_Y;
      end
    end
    if (state == ST_DROP && !out_ack) clear = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      src     <= SRC_X;
      out_req <= 1'b0;
      x_ack   <= 1'b0;
      y_ack   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load) begin
            src   <= load_src;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          out_req <= 1'b1;
          state   <= ST_PUSH;
        end
        ST_PUSH: begin
          if (out_ack) begin
            out_req <= 1'b0;
            state   <= ST_DROP;
          end
        end
        ST_DROP: begin
          if (!out_ack) begin
            if (src == SRC_X) x_ack <= 1'b1;
            else              y_ack <= 1'b1;
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (!src_req) begin
            x_ack <= 1'b0;
            y_ack <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_excl_req_R10: assert property (@(posedge clk) disable iff (rst)
    !(x_req && y_req));

  assert_one_ack_R10: assert property (@(posedge clk) disable iff (rst)
    !(x_ack && y_ack));

  assert_ack_after_out_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(x_ack) || $rose(y_ack)) |-> (!out_req && !$past(out_ack)));

  assert_no_req_in_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (x_ack || y_ack) |-> !out_req);

  assert_ack_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(x_ack) |-> !$past(x_req));

  assert_ack_fall_y_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(y_ack) |-> !$past(y_req));

endmodule

// File: rtl/hs_merge_dpath.sv
module hs_merge_dpath
  import hs_merge_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  merge_src_t    load_src,
  input  logic          clear,
  input  logic [DW-1:0] x_data,
  input  logic [DW-1:0] y_data,
  output logic [DW-1:0] out_data
);

  logic [DW-1:0] picked;

  assign picked = (load_src == SRC_X) ? x_data : y_data;

  always_ff @(posedge clk) begin
    if (rst)        out_data <= '0;
    else if (clear) out_data <= '0;
    else if (load)  out_data <= picked;
  end

endmodule

// File: rtl/hs_merge_top.sv
module hs_merge_top
  import hs_merge_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          x_req,
  output logic          x_ack,
  input  logic [DW-1:0] x_data,
  input  logic          y_req,
  output logic          y_ack,
  input  logic [DW-1:0] y_data,
  output logic          out_req,
  input  logic          out_ack,
  output logic [DW-1:0] out_data
);

  logic       load;
  logic       clear;
  merge_src_t load_src;

  hs_merge_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .x_req    (x_req),
    .y_req    (y_req),
    .out_ack  (out_ack),
    .x_ack    (x_ack),
    .y_ack    (y_ack),
    .out_req  (out_req),
    .load     (load),
    .load_src (load_src),
    .clear    (clear)
  );

  hs_merge_dpath #(.DW(DW)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_src (load_src),
    .clear    (clear),
    .x_data   (x_data),
    .y_data   (y_data),
    .out_data (out_data)
  );

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_req && !x_ack && !y_ack && out_data == '0));

  assert_setup_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_req) |-> $stable(out_data));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_req && $past(out_req)) |-> $stable(out_data));

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(x_ack) || $rose(y_ack)) |-> (out_data == '0));

endmodule

// File: tb/tb_hs_merge_top.sv
module tb_hs_merge_top;
  localparam int DW = 8;
  localparam int NV = 10;

  // vector: {src(1), data(8), ack_delay(4), hold(4)}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'hA5, 4'd0, 4'd0},
    {1'b1, 8'h3C, 4'd2, 4'd1},
    {1'b0, 8'hFF, 4'd5, 4'd3},
    {1'b0, 8'h01, 4'd1, 4'd0},
    {1'b1, 8'h80, 4'd0, 4'd2},
    {1'b1, 8'h7E, 4'd3, 4'd0},
    {1'b0, 8'h00, 4'd2, 4'd1},
    {1'b1, 8'hC3, 4'd7, 4'd4},
    {1'b0, 8'h5A, 4'd0, 4'd2},
    {1'b1, 8'h96, 4'd1, 4'd1}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          x_req, y_req, out_ack;
  logic [DW-1:0] x_data, y_data;
  logic          x_ack, y_ack, out_req;
  logic [DW-1:0] out_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hs_merge_top #(.DW(DW)) dut (
    .clk(clk), .rst(rst),
    .x_req(x_req), .x_ack(x_ack), .x_data(x_data),
    .y_req(y_req), .y_ack(y_ack), .y_data(y_data),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic xfer(input bit src, input logic [DW-1:0] d, input int dly, input int hold);
    logic [DW-1:0] prev;
    int n;
    logic sack, oack;
    if (src) y_data = d; else x_data = d;
    @(negedge clk);
    if (src) y_req = 1'b1; else x_req = 1'b1;
    prev = out_data;
    n = 0;
    @(negedge clk);
    while (!out_req && n < 50) begin
      prev = out_data;
      @(negedge clk);
      n++;
    end
    // R2 / R3: data of the accepted input on the output
    check(out_data == d, src ? "R3" : "R2", out_data, d);
    // R4: data already present the cycle before the request
    check(prev == d, "R4", prev, d);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      // R5: steady while request is high
      check(out_req && out_data == d, "R5", out_data, d);
    end
    out_ack = 1'b1;
    n = 0;
    @(negedge clk);
    while (out_req && n < 50) begin @(negedge clk); n++; end
    sack = src ? y_ack : x_ack;
    // R6: no input ack while output ack still high
    check(!sack, "R6", sack, 0);
    out_ack = 1'b0;
    n = 0;
    @(negedge clk);
    while (!(src ? y_ack : x_ack) && n < 50) begin @(negedge clk); n++; end
    check((src ? y_ack : x_ack) == 1'b1, "R6", n, 0);
    // R7: cleared data at ack
    check(out_data == '0, "R7", out_data, 0);
    // R9: no output request during ack
    check(!out_req, "R9", out_req, 0);
    oack = src ? x_ack : y_ack;
    // R10: other input never acknowledged
    check(!oack, "R10", oack, 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check((src ? y_ack : x_ack) == 1'b1, "R8", 0, 1);
    end
    if (src) y_req = 1'b0; else x_req = 1'b0;
    @(negedge clk);
    sack = src ? y_ack : x_ack;
    check(!sack, "R8", sack, 0);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst = 1'b1; x_req = 0; y_req = 0; out_ack = 0; x_data = 0; y_data = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!out_req && !x_ack && !y_ack && out_data == '0, "R1", out_data, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++)
      xfer(VEC[v][16], VEC[v][15:8], int'(VEC[v][7:4]), int'(VEC[v][3:0]));

    // R10: other input's data changes during a cycle do not reach the output
    y_data = 8'h11;
    fork
      xfer(1'b0, 8'h42, 2, 1);
      begin
        repeat (3) @(negedge clk);
        y_data = 8'hEE;
      end
    join
    check(!y_ack && out_data == '0, "R10", out_data, 0);

    // R1: reset in the middle of a transfer
    x_data = 8'h77;
    @(negedge clk); x_req = 1'b1;
    repeat (3) @(negedge clk);
    x_req = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!out_req && !x_ack && out_data == '0, "R1", out_data, 0);
    rst = 1'b0;
    @(negedge clk);
    xfer(1'b1, 8'hB4, 1, 0);

    finish_run();
  end
endmodule